// File: doc/BRIEF.md
# Segment Selector Load Unit

This block places a 16-bit selector into one of six segment registers. It splits the selector into its fields and checks it against the global descriptor table register, which is supplied on input ports as a base address and a byte limit. For a selector that passes the checks, it fetches the 8-byte descriptor through a simple read port with request and valid signals. It then decodes the descriptor into a hidden cache for that register. The cache holds the 32-bit base, the 20-bit limit, the granularity flag, the default operand size flag, the 2-bit privilege level and a usable marker.

A null selector (table bit 0, index 0) may be loaded into the four data registers. No memory read takes place, and the cache entry is marked unusable so that later accesses through it can be refused. Loading a null selector into the code or stack register is illegal. A local-table selector is illegal, and so is a descriptor that lies past the table limit. An illegal load raises a one-cycle fault pulse with a cause code and leaves every register as it was.

The unit handles one load at a time. While a load is in progress, busy is high and new requests are not taken. Any register's visible selector and cached descriptor can be read back at any time through a combinational read port.

Top module: `seg_load_unit`

## Requirements
- R1: After reset, all six registers hold selector 0 with base, limit, flags and DPL at 0 and the usable marker at 0; busy, fault, done and mem_req are all 0.
- R2: In a selector, bits [15:3] are the index, bit 2 selects the table (0 = global), and bits [1:0] are the requested privilege. A selector with bit 2 set gives fault cause 1, issues no memory read and changes no register.
- R3: For an accepted legal non-null selector, mem_req rises with mem_addr equal to table base + index*8 (modulo 2^64). It stays high with a stable address until a cycle in which mem_rvalid is 1.
- R4: If index*8+7 is greater than the table limit, the load gives fault cause 2, issues no memory read and changes no register. When index*8+7 equals the limit, the load proceeds.
- R5: A fetched descriptor is decoded as follows: base = {d[63:56], d[39:16]}, limit = {d[51:48], d[15:0]}, granularity = d[55], default size = d[54], DPL = d[46:45]. These fields are stored with the full selector and the usable marker at 1, and done pulses in the cycle after the edge where mem_rvalid was seen.
- R6: A null selector (bits [15:2] all 0) loaded into register 2, 3, 4 or 5 (DS, ES, FS, GS) issues no memory read and raises no fault. The full selector (RPL included) is stored with base, limit, flags and DPL at 0 and the usable marker at 0.
- R7: A null selector loaded into register 0 (CS) or register 1 (SS) gives fault cause 3 and changes no register.
- R8: A request is taken when ld_valid is 1, busy is 0 and ld_reg < 6. busy is high from the cycle after acceptance until the cycle in which done or fault is shown; in that cycle busy is 0. done and fault are single-cycle pulses, and they never occur together.
- R9: Fault checks are applied in a fixed priority: table bit (cause 1) first, then null into CS/SS (cause 3), then the limit check (cause 2).
- R10: Requests presented while busy is high are ignored, and a load changes only the register it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request |
| ld_reg | input | 3 | Target register: 0 CS, 1 SS, 2 DS, 3 ES, 4 FS, 5 GS |
| ld_sel | input | 16 | Selector to load |
| tbl_base | input | 64 | Global table base address |
| tbl_limit | input | 16 | Global table byte limit |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 64 | Descriptor byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Descriptor data |
| busy | output | 1 | Load in progress |
| done | output | 1 | Cache written (one-cycle pulse) |
| fault | output | 1 | Illegal load (one-cycle pulse) |
| fault_cause | output | 2 | 1 local table, 2 limit, 3 null into CS/SS |
| rd_reg | input | 3 | Register to read back |
| rd_sel | output | 16 | Visible selector |
| rd_base | output | 32 | Cached base |
| rd_limit | output | 20 | Cached limit |
| rd_gran | output | 1 | Cached granularity flag |
| rd_dsize | output | 1 | Cached default size flag |
| rd_dpl | output | 2 | Cached DPL |
| rd_usable | output | 1 | 1 = usable descriptor, 0 = null |

## Verification
The assertions check the handshake and sequencing on every cycle. They cover the following: the read request stays up with a steady address until data arrives, a request never appears without busy, busy falls only together with done or fault, the pulses last one cycle and never coincide, and a fault always carries a nonzero cause. Other behaviour can be shown only by the bench's scenarios, which compare a behavioural model cycle by cycle. This covers the descriptor field decode, the address arithmetic including wrap-around, the limit boundary at equality, the fault priority, the null-selector handling per register, and the claim that ignored or faulting requests leave all six caches untouched.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int NUM_SEG = 6;
    localparam int SEL_W   = 16;
    localparam int IDX_W   = SEL_W - 3;
    localparam int DESC_W  = 64;

    typedef enum logic [2:0] {
        SEG_CS = 3'd0, SEG_SS = 3'd1, SEG_DS = 3'd2,
        SEG_ES = 3'd3, SEG_FS = 3'd4, SEG_GS = 3'd5
    } seg_id_e;

    typedef enum logic [1:0] {
        CAUSE_NONE       = 2'd0,
        CAUSE_LOCAL_TBL  = 2'd1,
        CAUSE_LIMIT      = 2'd2,
        CAUSE_NULL_CS_SS = 2'd3
    } fault_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_FETCH = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [31:0]      base;
        logic [19:0]      limit;
        logic             gran;
        logic             dsize;
        logic [1:0]       dpl;
        logic             usable;
    } seg_cache_t;

    function automatic seg_cache_t null_entry(input logic [SEL_W-1:0] sel);
        seg_cache_t e;
        e        = '0;
        e.sel    = sel;
        e.usable = 1'b0;
        return e;
    endfunction
endpackage

// File: rtl/seg_sel_check.sv
module seg_sel_check
    import seg_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LIM_W  = 16
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [2:0]        reg_id,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [LIM_W-1:0]  tbl_limit,
    output fault_cause_e      cause,
    output logic              is_null,
    output logic [ADDR_W-1:0] desc_addr
);
    localparam int OFF_W = IDX_W + 3;

    logic [IDX_W-1:0] index;
    logic             ti;
    logic [OFF_W-1:0] last_byte;
    logic             code_or_stack;
    logic             over_limit;
    logic             unused_rpl;

    assign index         = sel[SEL_W-1:3];
    assign ti            = sel[2];
    assign unused_rpl    = ^sel[1:0];
    assign last_byte     = {index, 3'b111};
    assign is_null       = (index == '0) && !ti;
    assign code_or_stack = (reg_id == SEG_CS) || (reg_id == SEG_SS);
    assign over_limit    = 32'(last_byte) > 32'(tbl_limit);
    assign desc_addr     = tbl_base + ADDR_W'({index, 3'b000});

    always_comb begin
        if (ti)
            cause = CAUSE_LOCAL_TBL;
        else if (is_null && code_or_stack)
            cause = CAUSE_NULL_CS_SS;
        else if (!is_null && over_limit)
            cause = CAUSE_LIMIT;
        else
            cause = CAUSE_NONE;
    end
endmodule

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
    import seg_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [SEL_W-1:0]  sel,
    output seg_cache_t        entry
);
    logic unused_bits;
    assign unused_bits = ^{desc[53:52], desc[47], desc[44:40]};

    always_comb begin
        entry.sel    = sel;
        entry.base   = {desc[63:56], desc[39:16]};
        entry.limit  = {desc[51:48], desc[15:0]};
        entry.gran   = desc[55];
        entry.dsize  = desc[54];
        entry.dpl    = desc[46:45];
        entry.usable = 1'b1;
    end
endmodule

// File: rtl/seg_reg_file.sv
module seg_reg_file
    import seg_pkg::*;
#(
    parameter int N = NUM_SEG
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_idx,
    input  seg_cache_t wr_data,
    input  logic [2:0] rd_idx,
    output seg_cache_t rd_data
);
    seg_cache_t entry_q [N];
    seg_cache_t entry_d [N];

    for (genvar i = 0; i < N; i++) begin : g_entry
        always_comb begin
            entry_d[i] = entry_q[i];
            if (wr_en && (wr_idx == 3'(i)))
                entry_d[i] = wr_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[i] <= null_entry('0);
            else
                entry_q[i] <= entry_d[i];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N; k++)
            if (rd_idx == 3'(k))
                rd_data = entry_q[k];
    end
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
    import seg_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [2:0]        ld_reg,
    input  logic [15:0]       ld_sel,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [LIM_W-1:0]  tbl_limit,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_cause,
    input  logic [2:0]        rd_reg,
    output logic [15:0]       rd_sel,
    output logic [31:0]       rd_base,
    output logic [19:0]       rd_limit,
    output logic              rd_gran,
    output logic              rd_dsize,
    output logic [1:0]        rd_dpl,
    output logic              rd_usable
);
    typedef struct packed {
        ld_state_e         st;
        logic [SEL_W-1:0]  sel;
        logic [2:0]        rid;
        logic [ADDR_W-1:0] addr;
        logic              fault;
        fault_cause_e      cause;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    fault_cause_e      chk_cause;
    logic              chk_null;
    logic [ADDR_W-1:0] chk_addr;
    seg_cache_t        dec_entry;
    seg_cache_t        wr_data;
    logic              wr_en;
    seg_cache_t        rd_entry;

    seg_sel_check #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_check (
        .sel       (ctl_q.sel),
        .reg_id    (ctl_q.rid),
        .tbl_base  (tbl_base),
        .tbl_limit (tbl_limit),
        .cause     (chk_cause),
        .is_null   (chk_null),
        .desc_addr (chk_addr)
    );

    seg_desc_decode u_decode (
        .desc  (mem_rdata),
        .sel   (ctl_q.sel),
        .entry (dec_entry)
    );

    seg_reg_file #(.N(NUM_SEG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (ctl_q.rid),
        .wr_data (wr_data),
        .rd_idx  (rd_reg),
        .rd_data (rd_entry)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.fault = 1'b0;
        ctl_d.done  = 1'b0;
        ctl_d.cause = CAUSE_NONE;
        wr_en       = 1'b0;
        wr_data     = dec_entry;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (ld_valid && (ld_reg < 3'(NUM_SEG))) begin
                    ctl_d.st  = ST_CHECK;
                    ctl_d.sel = ld_sel;
                    ctl_d.rid = ld_reg;
                end
            end
            ST_CHECK: begin
                if (chk_cause != CAUSE_NONE) begin
                    ctl_d.fault = 1'b1;
                    ctl_d.cause = chk_cause;
                    ctl_d.st    = ST_IDLE;
                end else if (chk_null) begin
                    wr_en      = 1'b1;
                    wr_data    = null_entry(ctl_q.sel);
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_IDLE;
                end else begin
                    ctl_d.addr = chk_addr;
                    ctl_d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_rvalid) begin
                    wr_en      = 1'b1;
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '{st: ST_IDLE, cause: CAUSE_NONE, default: '0};
        else
            ctl_q <= ctl_d;
    end

    assign mem_req     = (ctl_q.st == ST_FETCH);
    assign mem_addr    = ctl_q.addr;
    assign busy        = (ctl_q.st != ST_IDLE);
    assign done        = ctl_q.done;
    assign fault       = ctl_q.fault;
    assign fault_cause = ctl_q.cause;

    assign rd_sel    = rd_entry.sel;
    assign rd_base   = rd_entry.base;
    assign rd_limit  = rd_entry.limit;
    assign rd_gran   = rd_entry.gran;
    assign rd_dsize  = rd_entry.dsize;
    assign rd_dpl    = rd_entry.dpl;
    assign rd_usable = rd_entry.usable;
endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              fault,
    input logic [1:0]        fault_cause,
    input logic              done
);
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    assert_req_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (fault || done));

    assert_no_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault && done));

    assert_fault_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_cause_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_cause != 2'd0));
endmodule

bind seg_load_unit seg_load_chk #(.ADDR_W(ADDR_W)) u_seg_load_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_rvalid  (mem_rvalid),
    .mem_addr    (mem_addr),
    .fault       (fault),
    .fault_cause (fault_cause),
    .done        (done)
);

// File: tb/tb_seg_load_unit.sv
`timescale 1ns/100ps
module tb_seg_load_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_reg = '0;
    logic [15:0] ld_sel = '0;
    logic [63:0] tbl_base = 64'h0000_1000_0000_0000;
    logic [15:0] tbl_limit = 16'h007F;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        busy, done, fault;
    logic [1:0]  fault_cause;
    logic [2:0]  rd_reg = '0;
    logic [15:0] rd_sel;
    logic [31:0] rd_base;
    logic [19:0] rd_limit;
    logic        rd_gran, rd_dsize, rd_usable;
    logic [1:0]  rd_dpl;

    always #5 clk = ~clk;

    seg_load_unit dut (.*);

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [15:0] m_sel [6];
    logic [31:0] m_base [6];
    logic [19:0] m_limit [6];
    logic        m_g [6], m_d [6], m_use [6];
    logic [1:0]  m_dpl [6];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 6; i++) begin
            rd_reg = 3'(i);
            #0.1;
            chk({tag, " sel"},    64'(rd_sel),    64'(m_sel[i]));
            chk({tag, " base"},   64'(rd_base),   64'(m_base[i]));
            chk({tag, " limit"},  64'(rd_limit),  64'(m_limit[i]));
            chk({tag, " gran"},   64'(rd_gran),   64'(m_g[i]));
            chk({tag, " dsize"},  64'(rd_dsize),  64'(m_d[i]));
            chk({tag, " dpl"},    64'(rd_dpl),    64'(m_dpl[i]));
            chk({tag, " usable"}, 64'(rd_usable), 64'(m_use[i]));
        end
    endtask

    // Drives one load and checks the ports in every cycle until it ends.
    task automatic do_load(input string tag, input int r, input logic [15:0] sel,
                           input logic [63:0] desc, input int lat,
                           input int exp_cause, input bit poke);
        logic        is_null;
        logic [63:0] exp_addr;
        is_null  = (sel[15:2] == '0);
        exp_addr = tbl_base + {48'd0, sel[15:3], 3'b000};
        @(negedge clk);
        ld_valid = 1'b1; ld_reg = 3'(r); ld_sel = sel;
        @(negedge clk);
        ld_valid = 1'b0;
        chk({tag, " R8 busy after accept"}, 64'(busy), 64'd1);
        chk({tag, " R8 no early pulse"}, 64'({fault, done, mem_req}), 64'd0);
        @(negedge clk);
        if (exp_cause != 0) begin
            chk({tag, " R9 fault"}, 64'(fault), 64'd1);
            chk({tag, " R9 cause"}, 64'(fault_cause), 64'(exp_cause));
            chk({tag, " R8 busy low at fault"}, 64'(busy), 64'd0);
            chk({tag, " R2 no read"}, 64'({mem_req, done}), 64'd0);
        end else if (is_null) begin
            chk({tag, " R6 done"}, 64'(done), 64'd1);
            chk({tag, " R6 no read/fault"}, 64'({mem_req, fault, busy}), 64'd0);
            m_sel[r] = sel; m_base[r] = '0; m_limit[r] = '0;
            m_g[r] = 0; m_d[r] = 0; m_dpl[r] = '0; m_use[r] = 0;
        end else begin
            chk({tag, " R3 req"}, 64'(mem_req), 64'd1);
            chk({tag, " R3 addr"}, mem_addr, exp_addr);
            for (int k = 0; k < lat; k++) begin
                if (poke && k == 0) begin
                    ld_valid = 1'b1; ld_reg = 3'd2; ld_sel = 16'h0028;
                end else begin
                    ld_valid = 1'b0;
                end
                @(negedge clk);
                chk({tag, " R3 req held"}, 64'(mem_req), 64'd1);
                chk({tag, " R3 addr held"}, mem_addr, exp_addr);
                chk({tag, " R8 busy held"}, 64'(busy), 64'd1);
            end
            ld_valid = 1'b0;
            mem_rvalid = 1'b1; mem_rdata = desc;
            @(negedge clk);
            mem_rvalid = 1'b0; mem_rdata = '0;
            chk({tag, " R5 done"}, 64'(done), 64'd1);
            chk({tag, " R8 idle at done"}, 64'({busy, mem_req, fault}), 64'd0);
            m_sel[r] = sel;
            m_base[r] = {desc[63:56], desc[39:16]};
            m_limit[r] = {desc[51:48], desc[15:0]};
            m_g[r] = desc[55]; m_d[r] = desc[54]; m_dpl[r] = desc[46:45]; m_use[r] = 1;
        end
        check_all({tag, " R10 regs"});
        @(negedge clk);
        chk({tag, " R8 pulse ended"}, 64'({done, fault, busy}), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 6; i++) begin
            m_sel[i] = '0; m_base[i] = '0; m_limit[i] = '0;
            m_g[i] = 0; m_d[i] = 0; m_dpl[i] = '0; m_use[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs idle", 64'({busy, done, fault, mem_req}), 64'd0);
        check_all("R1 reset");

        do_load("R5 CS flat", 0, 16'h0010, 64'h00CF_9A00_0000_FFFF, 0, 0, 0);
        do_load("R5 SS odd", 1, 16'h002B, 64'h12CF_F234_5678_ABCD, 3, 0, 1);
        do_load("R6 DS null", 2, 16'h0003, 64'd0, 0, 0, 0);
        do_load("R7 CS null", 0, 16'h0000, 64'd0, 0, 3, 0);
        do_load("R7 SS null", 1, 16'h0002, 64'd0, 0, 3, 0);
        do_load("R2 ES local", 3, 16'h0014, 64'd0, 0, 1, 0);
        do_load("R4 GS over", 5, 16'h0080, 64'd0, 0, 2, 0);
        do_load("R4 GS at limit", 5, 16'h007B, 64'h0040_9200_1000_0FFF, 1, 0, 0);
        do_load("R9 local over null", 1, 16'h0004, 64'd0, 0, 1, 0);
        tbl_limit = 16'h0000;
        do_load("R9 null over limit", 0, 16'h0000, 64'd0, 0, 3, 0);
        do_load("R6 FS null limit0", 4, 16'h0001, 64'd0, 0, 0, 0);
        tbl_limit = 16'h007F;
        tbl_base = 64'hFFFF_FFFF_FFFF_FFF8;
        do_load("R3 FS wrap", 4, 16'h0008, 64'hAB40_F6CD_EF01_2345, 2, 0, 0);
        tbl_base = 64'h0000_1000_0000_0000;
        do_load("R5 ES reload", 3, 16'h0018, 64'h0080_9312_3456_0000, 0, 0, 0);

        @(negedge clk);
        ld_valid = 1'b1; ld_reg = 3'd6; ld_sel = 16'h0010;
        @(negedge clk);
        ld_valid = 1'b0;
        chk("R8 reg id 6 not taken", 64'(busy), 64'd0);
        check_all("R10 after bad id");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule